// File: doc/BRIEF.md
# Configurable True Dual-Port RAM

This block is an 18-kbit synchronous memory with two ports, A and B, that work fully independently. Each port has its own clock, enable, write enable, address, data input and parity input, plus a registered data output and a registered parity output. Either port may read or write any location at any time. When a port writes, it also reads: its output register is reloaded on the same edge as the write.

A parameter picks the shape of the memory, shared by both ports. The widths 1, 2 and 4 have depths of 16384, 8192 and 4096 and carry no parity. The widths 9, 18 and 36 have depths of 2048, 1024 and 512. In those shapes the word is 8, 16 or 32 data bits plus 1, 2 or 4 parity bits. The parity bits are stored and returned as ordinary bits on a bus of their own.

A second parameter picks what a port outputs on a write edge: the new data (write-first) or the old contents of that location (read-first). Each port's clock can be set to act on its rising or its falling edge. Each port also has a synchronous set/reset that loads a parameter value into its output register. The data flow is a plain memory access with a fixed one-edge latency, so the ports have no valid/ready handshake and there is no back-pressure. A result appears in the output register one active edge after the request. A caller that needs flow control builds it around the block.

Top module: `tdp_ram`

## Requirements
- R1: When enable and write enable are both high on a port's active edge, the word {parity, data} is stored at the presented address. A later read from either port returns it.
- R2: When enable is high and write enable is low on an active edge, the port's output register loads the word at the presented address, one edge after the request.
- R3: In write-first mode, a write edge loads the output register with the word just written.
- R4: In read-first mode, a write edge loads the output register with the contents the location held before the write.
- R5: While enable is low, the output register keeps its value and no write happens, whatever the write enable does.
- R6: With enable high, the set/reset input loads the output register with that port's set value on the active edge. A write on the same edge is still stored, and memory contents are never changed by set/reset.
- R7: With enable low, the set/reset input has no effect on the output register.
- R8: A port set to the falling edge does nothing on rising edges and acts only on falling edges.
- R9: Each port reads what the other port wrote, at both address 0 and the top address (511 in the 36-bit shape).
- R10: In the 36-bit shape, parity input bit k is stored as word bit 32+k and comes back on parity output bit k, separately from the 32 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock; active edge set by CLK_A_FALLING |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable (qualified by en_a) |
| sreset_a | input | 1 | Port A synchronous output set/reset |
| addr_a | input | AW (9) | Port A address |
| din_a | input | DW (32) | Port A write data |
| dinp_a | input | PPW (4) | Port A write parity |
| dout_a | output | DW (32) | Port A registered read data |
| doutp_a | output | PPW (4) | Port A registered read parity |
| clk_b | input | 1 | Port B clock; active edge set by CLK_B_FALLING |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable (qualified by en_b) |
| sreset_b | input | 1 | Port B synchronous output set/reset |
| addr_b | input | AW (9) | Port B address |
| din_b | input | DW (32) | Port B write data |
| dinp_b | input | PPW (4) | Port B write parity |
| dout_b | output | DW (32) | Port B registered read data |
| doutp_b | output | PPW (4) | Port B registered read parity |

## Verification
Two copies of the block, one write-first and one read-first, receive the same stimulus. Port A is rising-edge and port B is falling-edge. A rewrite of a location that already holds a word is what separates the two modes; a plain read must give the same result in both copies. The stimulus covers these patterns:
- Writes on one port followed by reads on the other, at addresses 0 and 511 and across a strided block, which show that the two ports share storage.
- Words with only parity bits set, or only data bits set, which show that the two buses are kept apart.
- Set/reset applied together with a write, and disabled cycles that carry write or set/reset requests, which separate changes to the output register from changes to storage.
- A check of port B's output just after a rising edge, which confirms that the falling-edge port ignored that edge.

// File: rtl/tdpr_pkg.sv
package tdpr_pkg;

  typedef enum logic {
    WR_NEW = 1'b0,
    WR_OLD = 1'b1
  } wmode_e;

  // data bits of a word for a given port width
  function automatic int data_bits(input int w);
    return (w == 36) ? 32 : (w == 18) ? 16 : (w == 9) ? 8 : w;
  endfunction

  // parity bits of a word for a given port width
  function automatic int par_bits(input int w);
    return w - data_bits(w);
  endfunction

  // address bits for a given port width (depth is 2**result)
  function automatic int addr_bits(input int w);
    case (w)
      1:       return 14;
      2:       return 13;
      4:       return 12;
      9:       return 11;
      18:      return 10;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/tdpr_bank.sv
// One storage bank: a single writer and two asynchronous read taps.
// Two banks combined by XOR give a memory that both ports can write.
module tdpr_bank #(
  parameter int AW = 9,
  parameter int W  = 36
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wword,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rword_a,
  output logic [W-1:0]  rword_b
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) cells[waddr] <= wword;
  end

  assign rword_a = cells[raddr_a];
  assign rword_b = cells[raddr_b];

endmodule

// File: rtl/tdpr_port.sv
// Output register of one port: set/reset, write-mode selection, hold.
module tdpr_port #(
  parameter int           W        = 36,
  parameter bit           SHOW_NEW = 1'b1,
  parameter logic [W-1:0] SET_VAL  = '0
) (
  input  logic         clk,
  input  logic         en,
  input  logic         we,
  input  logic         sreset,
  input  logic [W-1:0] new_word,
  input  logic [W-1:0] old_word,
  output logic [W-1:0] q
);
  logic         armed = 1'b0;
  logic [W-1:0] next_q;

  always_ff @(posedge clk) armed <= 1'b1;

  always_comb begin
    if (sreset)               next_q = SET_VAL;
    else if (we && SHOW_NEW)  next_q = new_word;
    else                      next_q = old_word;
  end

  always_ff @(posedge clk) begin
    if (en) q <= next_q;
  end

  // R5 / R7: a disabled edge leaves the register alone
  assert_hold_R5: assert property (@(posedge clk) disable iff (!armed)
    !en |=> $stable(q));

  // R6: enabled set/reset loads the set value
  assert_sreset_R6: assert property (@(posedge clk) disable iff (!armed)
    (en && sreset) |=> (q == SET_VAL));

  generate
    if (SHOW_NEW) begin : g_new_chk
      // R3: write edge shows the written word
      assert_wrfirst_R3: assert property (@(posedge clk) disable iff (!armed)
        (en && we && !sreset) |=> (q == $past(new_word)));
    end else begin : g_old_chk
      // R4: write edge shows the prior contents
      assert_rdfirst_R4: assert property (@(posedge clk) disable iff (!armed)
        (en && we && !sreset) |=> (q == $past(old_word)));
    end
  endgenerate

  // R2: a read returns the stored word
  assert_read_R2: assert property (@(posedge clk) disable iff (!armed)
    (en && !we && !sreset) |=> (q == $past(old_word)));

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int                 PORT_WIDTH    = 36,
  parameter tdpr_pkg::wmode_e   WRITE_MODE    = tdpr_pkg::WR_NEW,
  parameter bit                 CLK_A_FALLING = 1'b0,
  parameter bit                 CLK_B_FALLING = 1'b0,
  parameter logic [PORT_WIDTH-1:0] SRVAL_A    = '0,
  parameter logic [PORT_WIDTH-1:0] SRVAL_B    = '0,
  localparam int AW  = tdpr_pkg::addr_bits(PORT_WIDTH),
  localparam int DW  = tdpr_pkg::data_bits(PORT_WIDTH),
  localparam int PW  = tdpr_pkg::par_bits(PORT_WIDTH),
  localparam int PPW = (PW > 0) ? PW : 1
) (
  input  logic          clk_a,
  input  logic          en_a,
  input  logic          we_a,
  input  logic          sreset_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  input  logic [PPW-1:0] dinp_a,
  output logic [DW-1:0] dout_a,
  output logic [PPW-1:0] doutp_a,
  input  logic          clk_b,
  input  logic          en_b,
  input  logic          we_b,
  input  logic          sreset_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  input  logic [PPW-1:0] dinp_b,
  output logic [DW-1:0] dout_b,
  output logic [PPW-1:0] doutp_b
);
  localparam int  W        = PORT_WIDTH;
  localparam bit  SHOW_NEW = (WRITE_MODE == tdpr_pkg::WR_NEW);

  logic         ck_a, ck_b;
  logic         wr_a, wr_b;
  logic [W-1:0] word_in_a, word_in_b;
  logic [W-1:0] q_a, q_b;
  // bank X is written by port A, bank Y by port B
  logic [W-1:0] x_at_a, x_at_b, y_at_a, y_at_b;
  logic [W-1:0] stored_a, stored_b;

  // per-port clock polarity
  assign ck_a = clk_a ^ CLK_A_FALLING;
  assign ck_b = clk_b ^ CLK_B_FALLING;

  assign wr_a = en_a & we_a;
  assign wr_b = en_b & we_b;

  // word assembly: parity above data
  generate
    if (PW > 0) begin : g_par
      assign word_in_a = {dinp_a, din_a};
      assign word_in_b = {dinp_b, din_b};
      assign doutp_a   = q_a[W-1:DW];
      assign doutp_b   = q_b[W-1:DW];
    end else begin : g_nopar
      assign word_in_a = din_a;
      assign word_in_b = din_b;
      assign doutp_a   = '0;
      assign doutp_b   = '0;
    end
  endgenerate

  assign dout_a = q_a[DW-1:0];
  assign dout_b = q_b[DW-1:0];

  // logical contents = X ^ Y at each address
  assign stored_a = x_at_a ^ y_at_a;
  assign stored_b = x_at_b ^ y_at_b;

  tdpr_bank #(.AW(AW), .W(W)) u_bank_x (
    .clk     (ck_a),
    .wr      (wr_a),
    .waddr   (addr_a),
    .wword   (word_in_a ^ y_at_a),
    .raddr_a (addr_a),
    .raddr_b (addr_b),
    .rword_a (x_at_a),
    .rword_b (x_at_b)
  );

  tdpr_bank #(.AW(AW), .W(W)) u_bank_y (
    .clk     (ck_b),
    .wr      (wr_b),
    .waddr   (addr_b),
    .wword   (word_in_b ^ x_at_b),
    .raddr_a (addr_a),
    .raddr_b (addr_b),
    .rword_a (y_at_a),
    .rword_b (y_at_b)
  );

  tdpr_port #(.W(W), .SHOW_NEW(SHOW_NEW), .SET_VAL(SRVAL_A)) u_port_a (
    .clk      (ck_a),
    .en       (en_a),
    .we       (we_a),
    .sreset   (sreset_a),
    .new_word (word_in_a),
    .old_word (stored_a),
    .q        (q_a)
  );

  tdpr_port #(.W(W), .SHOW_NEW(SHOW_NEW), .SET_VAL(SRVAL_B)) u_port_b (
    .clk      (ck_b),
    .en       (en_b),
    .we       (we_b),
    .sreset   (sreset_b),
    .new_word (word_in_b),
    .old_word (stored_b),
    .q        (q_b)
  );

endmodule

// File: tb/test_tdp_ram.sv
module test_tdp_ram;
  localparam int CLK_PERIOD = 10;
  localparam logic [35:0] SV_A = 36'h9_1234_5678;
  localparam logic [35:0] SV_B = 36'h6_0F0F_F0F0;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        en_a = 0, we_a = 0, sr_a = 0, en_b = 0, we_b = 0, sr_b = 0;
  logic [8:0]  addr_a = '0, addr_b = '0;
  logic [31:0] din_a = '0, din_b = '0;
  logic [3:0]  dinp_a = '0, dinp_b = '0;
  logic [31:0] wf_da, wf_db, rf_da, rf_db;
  logic [3:0]  wf_pa, wf_pb, rf_pa, rf_pb;

  tdp_ram #(.PORT_WIDTH(36), .WRITE_MODE(tdpr_pkg::WR_NEW),
            .CLK_A_FALLING(1'b0), .CLK_B_FALLING(1'b1),
            .SRVAL_A(SV_A), .SRVAL_B(SV_B)) i_tdp_ram (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .sreset_a(sr_a), .addr_a(addr_a),
    .din_a(din_a), .dinp_a(dinp_a), .dout_a(wf_da), .doutp_a(wf_pa),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .sreset_b(sr_b), .addr_b(addr_b),
    .din_b(din_b), .dinp_b(dinp_b), .dout_b(wf_db), .doutp_b(wf_pb));

  tdp_ram #(.PORT_WIDTH(36), .WRITE_MODE(tdpr_pkg::WR_OLD),
            .CLK_A_FALLING(1'b0), .CLK_B_FALLING(1'b1),
            .SRVAL_A(SV_A), .SRVAL_B(SV_B)) i_tdp_ram_rf (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .sreset_a(sr_a), .addr_a(addr_a),
    .din_a(din_a), .dinp_a(dinp_a), .dout_a(rf_da), .doutp_a(rf_pa),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .sreset_b(sr_b), .addr_b(addr_b),
    .din_b(din_b), .dinp_b(dinp_b), .dout_b(rf_db), .doutp_b(rf_pb));

  typedef struct {
    logic [35:0] wf;
    logic [35:0] rf;
    string       tag;
  } exp_t;

  exp_t        qa[$];
  exp_t        qb[$];
  exp_t        ea, eb;
  logic [35:0] mdl [512];
  logic [35:0] last_wa = 'x, last_ra = 'x, last_wb = 'x, last_rb = 'x;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    if ($isunknown(exp)) return;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // expected outputs of one enabled/disabled access
  task automatic model(input logic en, we, sr, input logic [8:0] a,
                       input logic [35:0] w, input logic [35:0] sv,
                       inout logic [35:0] lw, inout logic [35:0] lr);
    logic [35:0] old;
    old = mdl[a];
    if (en) begin
      if (sr)      begin lw = sv;  lr = sv;  end
      else if (we) begin lw = w;   lr = old; end
      else         begin lw = old; lr = old; end
      if (we) mdl[a] = w;
    end
  endtask

  // driver, port A (rising edge)
  task automatic op_a(input logic en, we, sr, input logic [8:0] a,
                      input logic [35:0] w, input string tag);
    exp_t e;
    @(negedge clk); #1;
    en_a = en; we_a = we; sr_a = sr; addr_a = a; {dinp_a, din_a} = w;
    model(en, we, sr, a, w, SV_A, last_wa, last_ra);
    e.wf = last_wa; e.rf = last_ra; e.tag = tag;
    qa.push_back(e);
    @(posedge clk); #1;
    en_a = 0; we_a = 0; sr_a = 0;
  endtask

  // driver, port B (falling edge); also confirms the rising edge is ignored
  task automatic op_b(input logic en, we, sr, input logic [8:0] a,
                      input logic [35:0] w, input string tag);
    exp_t e;
    @(negedge clk); #1;
    en_b = en; we_b = we; sr_b = sr; addr_b = a; {dinp_b, din_b} = w;
    @(posedge clk); #2;
    chk({wf_pb, wf_db}, last_wb, {"R8 rising edge ignored: ", tag});
    chk({rf_pb, rf_db}, last_rb, {"R8 rising edge ignored rf: ", tag});
    model(en, we, sr, a, w, SV_B, last_wb, last_rb);
    e.wf = last_wb; e.rf = last_rb; e.tag = tag;
    qb.push_back(e);
    @(negedge clk); #1;
    en_b = 0; we_b = 0; sr_b = 0;
  endtask

  // monitors
  always @(posedge clk) begin
    #2;
    if (qa.size() > 0) begin
      ea = qa.pop_front();
      chk({wf_pa, wf_da}, ea.wf, {"A write-first: ", ea.tag});
      chk({rf_pa, rf_da}, ea.rf, {"A read-first: ", ea.tag});
    end
  end

  always @(negedge clk) begin
    #2;
    if (qb.size() > 0) begin
      eb = qb.pop_front();
      chk({wf_pb, wf_db}, eb.wf, {"B write-first: ", eb.tag});
      chk({rf_pb, rf_db}, eb.rf, {"B read-first: ", eb.tag});
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 'x;
    repeat (2) @(posedge clk);
    op_a(1, 0, 1, 9'd0, '0, "R6 reset state A");
    op_b(1, 0, 1, 9'd0, '0, "R6 reset state B");
    op_a(1, 1, 0, 9'd0, 36'hA_1111_2222, "R1 R3 first write");
    op_a(1, 1, 0, 9'd0, 36'h5_3333_4444, "R3 R4 rewrite shows new/old");
    op_b(1, 0, 0, 9'd0, '0, "R2 R9 B reads A word at 0");
    op_b(1, 1, 0, 9'd511, 36'hF_DEAD_BEEF, "R1 R8 B write top address");
    op_a(1, 0, 0, 9'd511, '0, "R9 A reads B word at 511");
    op_a(0, 1, 0, 9'd511, 36'h0_0000_0001, "R5 disabled write holds");
    op_a(1, 0, 0, 9'd511, '0, "R5 disabled write not stored");
    op_a(0, 0, 1, 9'd511, '0, "R7 set/reset ignored when disabled");
    op_a(1, 1, 1, 9'd5, 36'h0_CAFE_F00D, "R6 set/reset with write");
    op_b(1, 0, 0, 9'd5, '0, "R6 write under set/reset stored");
    op_b(1, 0, 1, 9'd511, '0, "R6 set/reset on B");
    op_a(1, 0, 0, 9'd511, '0, "R6 contents unchanged by set/reset");
    op_a(1, 1, 0, 9'd7, 36'hF_0000_0000, "R10 parity-only write");
    op_a(1, 1, 0, 9'd8, 36'h0_FFFF_FFFF, "R10 data-only write");
    op_b(1, 0, 0, 9'd7, '0, "R10 parity-only read");
    op_b(1, 0, 0, 9'd8, '0, "R10 data-only read");
    for (int i = 0; i < 12; i++)
      op_a(1, 1, 0, 9'(20 + 3*i), {4'(i), 32'h0101_0101 * 32'(i + 1)}, "R1 stride write");
    for (int i = 0; i < 12; i++)
      op_b(1, 0, 0, 9'(20 + 3*i), '0, "R2 R9 stride read");
    op_b(1, 1, 0, 9'd23, 36'h3_7777_8888, "R3 R4 B rewrite");
    op_a(1, 0, 0, 9'd23, '0, "R9 A reads B rewrite");
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule